// File: doc/BRIEF.md
# Predicated Functional Unit

A fixed-point, word-wide functional unit for one cell of a coarse-grained reconfigurable array. An issue strobe, a one-bit guard, a four-bit opcode and two data operands arrive each cycle. When the strobe and the guard are both high, the operation executes. A low guard cancels the operation completely: no output register moves and no valid pulse appears. A new operation may issue on every clock.

The unit has two result classes. Data operations cover add, subtract, multiply, bitwise logic, pass, invert, shifts and set-on-less-than. They write a registered word result. Predicate operations are three compares, and each writes a pair of complementary one-bit results instead of a word. Every output comes straight from a flop.

Multiply needs both pipeline stages, because the product is formed from the registered operands. Every other operation is computed before the first stage register and then carried through the second. Every operation therefore reaches the ports at the same depth, so results retire in issue order with no stall and no collision.

Top module: `pred_fu`

## Requirements
- R1: A synchronous active-high `rst` clears `dst_data` to 0 and clears `pdst_t`, `pdst_f`, `dst_vld` and `pdst_vld` to 0.
- R2: An operation that is sampled with `pred` = 0, or with `issue` = 0, is cancelled. No valid pulse results from it, and `dst_data`, `pdst_t` and `pdst_f` keep their values.
- R3: An operation sampled at rising edge k with `issue` = 1 and `pred` = 1 shows its result and a one-cycle valid pulse after edge k+1. This holds for every opcode. Operations issued back-to-back retire one per cycle in issue order.
- R4: Arithmetic opcodes work modulo 2^W. Opcode 0 gives src_a+src_b, opcode 1 gives src_a−src_b, and opcode 8 gives the low W bits of src_a×src_b.
- R5: Logic opcodes are: 2 gives AND, 3 gives OR and 4 gives XOR. Opcode 9 gives src_a and opcode 10 gives ~src_a. The single-source opcodes 9 and 10 ignore src_b.
- R6: Shift opcodes shift src_a by the amount in src_b[log2(W)-1:0]: 5 shifts left, 6 shifts right logically and 7 shifts right arithmetically. Higher bits of src_b are ignored.
- R7: Opcode 11 writes 1 to `dst_data` when src_a < src_b as signed values and 0 otherwise. Opcode 15 does the same with an unsigned compare.
- R8: Predicate opcodes are 12 (equal), 13 (signed less-than) and 14 (unsigned less-than). Each sets `pdst_t` to the compare result and `pdst_f` to its complement, and pulses `pdst_vld`. `dst_data` is left unchanged and `dst_vld` stays low.
- R9: Data opcodes (every opcode except 12, 13 and 14) pulse `dst_vld` only. They leave `pdst_t` and `pdst_f` unchanged, and `pdst_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| pred | input | 1 | Guard: 1 executes the operation, 0 cancels it |
| opcode | input | 4 | Operation select |
| src_a | input | W | First data operand |
| src_b | input | W | Second data operand / shift amount |
| dst_data | output | W | Registered word result |
| dst_vld | output | 1 | One-cycle pulse when dst_data takes a new result |
| pdst_t | output | 1 | Registered compare result |
| pdst_f | output | 1 | Registered complement of the compare result |
| pdst_vld | output | 1 | One-cycle pulse when the predicate pair updates |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- A multiply followed at once by a single-cycle operation. A unit with unequal port latencies would collide on this pair or swap the order.
- Cancelled operations placed between live ones. Logic that ignored the guard would raise a pulse or overwrite a held output.
- Shift amounts with high bits set, such as 33. A unit that used the full src_b would produce 0 instead of a one-place shift.
- Signed and unsigned compares on operands whose sign bits differ. These expose a swapped compare flavour.
- A predicate operation immediately after a data operation, and the reverse. These catch one class disturbing the other's registers.
- Operand wrap-around on add, subtract and multiply.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SRA  = 4'd7,
    OP_MUL  = 4'd8,
    OP_PASS = 4'd9,
    OP_INV  = 4'd10,
    OP_SLT  = 4'd11,
    OP_PEQ  = 4'd12,
    OP_PLT  = 4'd13,
    OP_PLTU = 4'd14,
    OP_SLTU = 4'd15
  } fu_op_e;

  function automatic logic op_is_pred(fu_op_e op);
    return (op == OP_PEQ) || (op == OP_PLT) || (op == OP_PLTU);
  endfunction

endpackage

// File: rtl/pfu_decode.sv
module pfu_decode
  import pfu_pkg::*;
(
  input  fu_op_e op,
  output logic   is_mul,
  output logic   is_pred
);
  always_comb begin
    is_mul  = (op == OP_MUL);
    is_pred = op_is_pred(op);
  end
endmodule

// File: rtl/pfu_alu.sv
module pfu_alu
  import pfu_pkg::*;
#(
  parameter int W = 32
) (
  input  fu_op_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res,
  output logic           cmp
);
  localparam int SHW = $clog2(W);

  function automatic logic [W-1:0] word_op(fu_op_e o, logic [W-1:0] x, logic [W-1:0] y);
    logic [SHW-1:0] sh;
    sh = y[SHW-1:0];
    case (o)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_XOR:  return x ^ y;
      OP_SHL:  return x << sh;
      OP_SHR:  return x >> sh;
      OP_SRA:  return W'($signed(x) >>> sh);
      OP_PASS: return x;
      OP_INV:  return ~x;
      OP_SLT:  return {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
      OP_SLTU: return {{(W-1){1'b0}}, (x < y)};
      default: return '0;
    endcase
  endfunction

  function automatic logic pred_op(fu_op_e o, logic [W-1:0] x, logic [W-1:0] y);
    case (o)
      OP_PEQ:  return x == y;
      OP_PLT:  return $signed(x) < $signed(y);
      OP_PLTU: return x < y;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    res = word_op(op, a, b);
    cmp = pred_op(op, a, b);
  end
endmodule

// File: rtl/pred_fu.sv
module pred_fu
  import pfu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         issue,
  input  logic         pred,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] dst_data,
  output logic         dst_vld,
  output logic         pdst_t,
  output logic         pdst_f,
  output logic         pdst_vld
);
  // issue-side events
  fu_op_e       op;
  logic         fire;
  logic         dec_mul;
  logic         dec_pred;
  logic [W-1:0] alu_res;
  logic         alu_cmp;

  // first stage
  logic         s1_vld;
  logic         s1_mul;
  logic         s1_pred;
  logic         s1_cmp;
  logic [W-1:0] s1_res;
  logic [W-1:0] s1_a;
  logic [W-1:0] s1_b;

  // second stage events
  logic [W-1:0] mul_lo;
  logic         retire_data;
  logic         retire_pred;

  assign op   = fu_op_e'(opcode);
  assign fire = issue & pred;

  pfu_decode u_dec (
    .op      (op),
    .is_mul  (dec_mul),
    .is_pred (dec_pred)
  );

  pfu_alu #(.W(W)) u_alu (
    .op  (op),
    .a   (src_a),
    .b   (src_b),
    .res (alu_res),
    .cmp (alu_cmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_mul  <= 1'b0;
      s1_pred <= 1'b0;
      s1_cmp  <= 1'b0;
      s1_res  <= '0;
      s1_a    <= '0;
      s1_b    <= '0;
    end else begin
      s1_vld <= fire;
      if (fire) begin
        s1_mul  <= dec_mul;
        s1_pred <= dec_pred;
        s1_cmp  <= alu_cmp;
        s1_res  <= alu_res;
        s1_a    <= src_a;
        s1_b    <= src_b;
      end
    end
  end

  assign mul_lo      = s1_a * s1_b;
  assign retire_data = s1_vld & ~s1_pred;
  assign retire_pred = s1_vld & s1_pred;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_data <= '0;
      dst_vld  <= 1'b0;
      pdst_t   <= 1'b0;
      pdst_f   <= 1'b0;
      pdst_vld <= 1'b0;
    end else begin
      dst_vld  <= retire_data;
      pdst_vld <= retire_pred;
      if (retire_data) dst_data <= s1_mul ? mul_lo : s1_res;
      if (retire_pred) begin
        pdst_t <= s1_cmp;
        pdst_f <= ~s1_cmp;
      end
    end
  end
endmodule

// File: rtl/pfu_checker.sv
module pfu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         issue,
  input logic         pred,
  input logic [3:0]   opcode,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [W-1:0] dst_data,
  input logic         dst_vld,
  input logic         pdst_t,
  input logic         pdst_f,
  input logic         pdst_vld
);
  logic op_pred_class;
  assign op_pred_class = (opcode == 4'd12) || (opcode == 4'd13) || (opcode == 4'd14);

  AST_CANCEL_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (issue && !pred) |=> ##1 (!dst_vld && !pdst_vld)); // R2

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!dst_vld && !$past(rst)) |-> $stable(dst_data)); // R2

  AST_EXEC_PULSES: assert property (@(posedge clk) disable iff (rst)
    (issue && pred) |=> ##1 (dst_vld || pdst_vld)); // R3

  AST_PRED_CLASS: assert property (@(posedge clk) disable iff (rst)
    (issue && pred && op_pred_class) |=> ##1 (pdst_vld && !dst_vld)); // R8

  AST_PRED_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    pdst_vld |-> (pdst_f == !pdst_t)); // R8

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
    !(dst_vld && pdst_vld)); // R9

  AST_PRED_HELD: assert property (@(posedge clk) disable iff (rst)
    (!pdst_vld && !$past(rst)) |-> ($stable(pdst_t) && $stable(pdst_f))); // R9
endmodule

bind pred_fu pfu_checker #(.W(W)) i_chk (.*);

// File: tb/test_pred_fu.sv
module test_pred_fu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue = 1'b0;
  logic         pred = 1'b0;
  logic [3:0]   opcode = 4'd0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic [W-1:0] dst_data;
  logic         dst_vld;
  logic         pdst_t;
  logic         pdst_f;
  logic         pdst_vld;

  pred_fu #(.W(W)) i_pred_fu (.*);

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_p;
    logic [31:0] d;
    bit          pt;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          mon_on = 1'b0;
  logic [31:0] last_d = '0;
  bit          last_p = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sra_model(logic [31:0] a, int sh);
    logic [31:0] fill;
    fill = {32{a[31]}};
    if (sh == 0) return a;
    return (a >> sh) | (~(32'hFFFF_FFFF >> sh) & fill);
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    exp_t        e;
    logic [63:0] p;
    int          sh;
    sh     = int'(b[4:0]);
    e.is_p = 1'b0;
    e.d    = '0;
    e.pt   = 1'b0;
    case (op)
      4'd0:  begin e.d = a + b; e.tag = "R4 add"; end
      4'd1:  begin e.d = a + (~b + 32'd1); e.tag = "R4 sub"; end
      4'd8:  begin p = {32'd0, a} * {32'd0, b}; e.d = p[31:0]; e.tag = "R4 mul"; end
      4'd2:  begin e.d = a & b; e.tag = "R5 and"; end
      4'd3:  begin e.d = a | b; e.tag = "R5 or"; end
      4'd4:  begin e.d = a ^ b; e.tag = "R5 xor"; end
      4'd9:  begin e.d = a; e.tag = "R5 pass"; end
      4'd10: begin e.d = a ^ 32'hFFFF_FFFF; e.tag = "R5 inv"; end
      4'd5:  begin e.d = a << sh; e.tag = "R6 shl"; end
      4'd6:  begin e.d = a >> sh; e.tag = "R6 shr"; end
      4'd7:  begin e.d = sra_model(a, sh); e.tag = "R6 sra"; end
      4'd11: begin e.d = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)) ? 32'd1 : 32'd0; e.tag = "R7 slt"; end
      4'd15: begin e.d = (a < b) ? 32'd1 : 32'd0; e.tag = "R7 sltu"; end
      4'd12: begin e.is_p = 1'b1; e.pt = (a == b); e.tag = "R8 peq"; end
      4'd13: begin e.is_p = 1'b1; e.pt = ((a ^ 32'h8000_0000) < (b ^ 32'h8000_0000)); e.tag = "R8 plt"; end
      default: begin e.is_p = 1'b1; e.pt = (a < b); e.tag = "R8 pltu"; end
    endcase
    return e;
  endfunction

  // driver: one call per cycle, results due two edges later (R3)
  task automatic drive(bit en, bit p, logic [3:0] op, logic [31:0] a, logic [31:0] b);
    exp_t e;
    @(negedge clk);
    issue  = en;
    pred   = p;
    opcode = op;
    src_a  = a;
    src_b  = b;
    if (en && p) begin
      e     = model(op, a, b);
      e.due = cyc + 2;
      q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 4'd0, '0, '0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.is_p) begin
          chk({e.tag, " pvld"}, {31'd0, pdst_vld}, 32'd1);
          chk({e.tag, " no dvld"}, {31'd0, dst_vld}, 32'd0);
          chk({e.tag, " t"}, {31'd0, pdst_t}, {31'd0, e.pt});
          chk({e.tag, " f"}, {31'd0, pdst_f}, {31'd0, ~e.pt});
          chk("R8 data untouched", dst_data, last_d);
          last_p = e.pt;
        end else begin
          chk({e.tag, " R3 dvld"}, {31'd0, dst_vld}, 32'd1);
          chk({e.tag, " value"}, dst_data, e.d);
          chk("R9 no pvld", {31'd0, pdst_vld}, 32'd0);
          chk("R9 pred untouched", {31'd0, pdst_t}, {31'd0, last_p});
          last_d = e.d;
        end
      end else begin
        chk("R2 no dvld", {31'd0, dst_vld}, 32'd0);
        chk("R2 no pvld", {31'd0, pdst_vld}, 32'd0);
        chk("R2 data held", dst_data, last_d);
        chk("R2 pred held", {31'd0, pdst_t}, {31'd0, last_p});
      end
    end
  end

  task automatic reset_and_check();
    @(negedge clk);
    mon_on = 1'b0;
    rst    = 1'b1;
    issue  = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 data", dst_data, '0);
    chk("R1 dvld", {31'd0, dst_vld}, 32'd0);
    chk("R1 t", {31'd0, pdst_t}, 32'd0);
    chk("R1 f", {31'd0, pdst_f}, 32'd0);
    chk("R1 pvld", {31'd0, pdst_vld}, 32'd0);
    rst    = 1'b0;
    last_d = '0;
    last_p = 1'b0;
    mon_on = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    reset_and_check();

    // R4 wrap-around, R5 single-source ops ignoring src_b
    drive(1, 1, 4'd0, 32'hFFFF_FFFF, 32'd1);
    drive(1, 1, 4'd1, 32'd0, 32'd1);
    drive(1, 1, 4'd8, 32'h0001_0000, 32'h0001_0000);
    drive(1, 1, 4'd8, 32'hFFFF_FFFD, 32'd5);
    drive(1, 1, 4'd9, 32'hDEAD_BEEF, 32'h1234_5678);
    drive(1, 1, 4'd10, 32'h0F0F_00FF, 32'hFFFF_FFFF);
    drive(1, 1, 4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00);
    drive(1, 1, 4'd3, 32'hF0F0_F0F0, 32'h0F00_0F00);
    drive(1, 1, 4'd4, 32'hAAAA_5555, 32'hFFFF_0000);
    // R6 shift amount uses low bits only (33 -> 1)
    drive(1, 1, 4'd5, 32'h8000_0001, 32'd33);
    drive(1, 1, 4'd6, 32'h8000_0000, 32'hFFFF_FFE4);
    drive(1, 1, 4'd7, 32'h8000_0000, 32'd31);
    drive(1, 1, 4'd7, 32'h4000_0000, 32'd4);
    // R7 signed vs unsigned on differing sign bits
    drive(1, 1, 4'd11, 32'hFFFF_FFFF, 32'd1);
    drive(1, 1, 4'd15, 32'hFFFF_FFFF, 32'd1);
    // R8 predicate ops right after data ops and the reverse
    drive(1, 1, 4'd12, 32'd7, 32'd7);
    drive(1, 1, 4'd13, 32'hFFFF_FFFF, 32'd1);
    drive(1, 1, 4'd14, 32'hFFFF_FFFF, 32'd1);
    drive(1, 1, 4'd0, 32'd3, 32'd4);
    drive(1, 1, 4'd12, 32'd1, 32'd2);
    // R3 multiply followed at once by single-cycle ops
    drive(1, 1, 4'd8, 32'd1234, 32'd5678);
    drive(1, 1, 4'd0, 32'd1, 32'd1);
    drive(1, 1, 4'd8, 32'd9, 32'd9);
    drive(1, 1, 4'd13, 32'd5, 32'd9);
    // R2 cancelled ops between live ones
    drive(1, 0, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive(1, 1, 4'd4, 32'd5, 32'd3);
    drive(1, 0, 4'd12, 32'd0, 32'd0);
    drive(0, 1, 4'd9, 32'h1111_1111, 32'd0);
    drive(1, 0, 4'd8, 32'd7, 32'd7);
    idle(3);

    for (int i = 0; i < 300; i++) begin
      drive(($urandom % 8) != 0, ($urandom % 4) != 0, 4'($urandom),
            (i % 5 == 0) ? 32'hFFFF_FFFF : $urandom, (i % 7 == 0) ? 32'h8000_0000 : $urandom);
    end
    idle(4);

    // R1 mid-run reset after a live result
    drive(1, 1, 4'd0, 32'h1234_0000, 32'd1);
    drive(1, 1, 4'd12, 32'd3, 32'd3);
    idle(4);
    reset_and_check();
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule